// File: doc/BRIEF.md
# Input Fault Protection Sequencing Controller

This block is the digital control and timing logic of a supply load switch. It watches four synchronous status inputs: an undervoltage comparator, an overvoltage comparator, an overtemperature indication and an active-high shutdown request. From them it drives two outputs. The first is a gate enable for the pass transistors. The second is a fault flag, modelled as the drive-low control of an open-drain pin, so a 1 on that output means the external flag line reads low.

The input supply counts as valid when it is neither under nor over its thresholds and the die is not hot. Once the input is valid and shutdown is low, a start-up wait runs before the switch closes. A second wait then runs before the flag is released. Any fault opens the switch and pulls the flag at once, and both waits start again from zero when the fault clears. Shutdown only opens the switch. It never pulls the flag.

Both waits count whole milliseconds, taken from a prescaler that divides the system clock. The tick divisor and both delays are parameters, so short values can be used in simulation. Threshold hysteresis is handled upstream of this block, in the comparators that drive the status inputs.

Top module: `supply_guard_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a fault-free input has been seen, `gate_en_o` is 0 and `flag_pull_low_o` is 1.
- R2: A 1 on any of `uv_low_i`, `ov_high_i` or `ot_hot_i` is applied at the third rising clock edge that samples it. From that edge on, `gate_en_o` is 0 and `flag_pull_low_o` is 1, with no millisecond delay.
- R3: Suppose the input becomes fault-free while `shdn_i` is 0. The controller starts its wait at the third edge that samples this. `gate_en_o` rises exactly ON_DELAY_MS*TICK_DIV+1 clock cycles after that.
- R4: When the switch has closed after a fault, `flag_pull_low_o` falls to 0 exactly FLAG_DELAY_MS*TICK_DIV+1 cycles after `gate_en_o` rose, provided no fault and no shutdown arrive during that wait.
- R5: A 1 on `shdn_i` clears `gate_en_o` at the third edge that samples it. Shutdown never sets `flag_pull_low_o` to 1. If the input is fault-free, shutdown sets `flag_pull_low_o` to 0 at that same edge.
- R6: When `shdn_i` returns to 0 with a fault-free input, the full start-up wait of R3 is timed again before `gate_en_o` rises. During that wait the flag stays released at 0.
- R7: While a fault is present, `gate_en_o` stays 0 whatever the level of `shdn_i`.
- R8: A fault arriving during either wait, including a short overtemperature pulse, resets both waits. After it clears, the complete start-up wait and then the complete flag wait are timed again.
- R9: A shutdown asserted part-way through the start-up wait discards the time already counted. After release, the wait counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| uv_low_i | input | 1 | 1 = input below the undervoltage threshold |
| ov_high_i | input | 1 | 1 = input above the overvoltage threshold |
| ot_hot_i | input | 1 | 1 = die temperature above its shutdown limit |
| shdn_i | input | 1 | 1 = shutdown request; opens the switch only |
| gate_en_o | output | 1 | 1 = pass transistors on |
| flag_pull_low_o | output | 1 | 1 = pull the open-drain fault flag low |

## Verification
The bench goes after the exact edges at which the two waits end. A timer that is off by one tick, or one that lets the prescaler phase leak in, closes the switch a cycle early or late. It also checks that shutdown never pulls the flag, including a shutdown asserted in mid-wait. A design that ties the flag to the switch state would drop the flag when shutdown is released. A short overtemperature pulse in the flag wait must restart both waits. A design that keeps the partial count would close the switch or release the flag too soon. Random stretches of overlapping faults and shutdowns check that a fault always wins over a shutdown release.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    SG_FAULT     = 3'd0,
    SG_WAIT_ON   = 3'd1,
    SG_WAIT_FLAG = 3'd2,
    SG_ON        = 3'd3,
    SG_DISABLED  = 3'd4
  } sg_state_e;

endpackage

// File: rtl/sg_sync_pipe.sv
module sg_sync_pipe #(
  parameter int          WIDTH     = 4,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RESET_VAL;
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sg_tick_gen.sv
module sg_tick_gen #(
  parameter int DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign cnt_en = 1'b1;

      always_comb begin
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/sg_delay_timer.sv
module sg_delay_timer #(
  parameter int TICK_DIV = 200000,
  parameter int DELAY_MS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int MW = $clog2(DELAY_MS + 1);
  localparam logic [MW-1:0] LIMIT = MW'(DELAY_MS);

  logic          tick;
  logic [MW-1:0] ms_q, ms_d;
  logic          ms_en;

  sg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  // Clear when idle, count ticks while running, hold at the limit.
  assign ms_en = !run || (tick && (ms_q != LIMIT));

  always_comb begin
    if (!run) ms_d = '0;
    else      ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  assign expired = run && (ms_q == LIMIT);

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl #(
  parameter int TICK_DIV      = 200000,
  parameter int ON_DELAY_MS   = 30,
  parameter int FLAG_DELAY_MS = 30,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_low_i,
  input  logic ov_high_i,
  input  logic ot_hot_i,
  input  logic shdn_i,
  output logic gate_en_o,
  output logic flag_pull_low_o
);
  import supply_guard_pkg::*;

  localparam int NUM_IN = 4;
  // Bit order: {shutdown, overtemp, overvoltage, undervoltage}; faults reset as present.
  localparam logic [NUM_IN-1:0] IN_RESET = 4'b0111;

  // Reset: asynchronous assert, synchronous release.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Input synchronizers.
  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              fault_s, shdn_s;

  assign raw_in = {shdn_i, ot_hot_i, ov_high_i, uv_low_i};

  sg_sync_pipe #(
    .WIDTH    (NUM_IN),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(IN_RESET)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (raw_in),
    .q    (sync_in)
  );

  assign fault_s = |sync_in[2:0];
  assign shdn_s  = sync_in[3];

  // Series timers.
  sg_state_e state_q, state_d;
  logic      on_run, flag_run, on_expired, flag_expired;

  assign on_run   = (state_q == SG_WAIT_ON);
  assign flag_run = (state_q == SG_WAIT_FLAG);

  sg_delay_timer #(.TICK_DIV(TICK_DIV), .DELAY_MS(ON_DELAY_MS)) u_on_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (on_run),
    .expired(on_expired)
  );

  sg_delay_timer #(.TICK_DIV(TICK_DIV), .DELAY_MS(FLAG_DELAY_MS)) u_flag_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (flag_run),
    .expired(flag_expired)
  );

  // Next state.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SG_FAULT:     if (!fault_s) state_d = shdn_s ? SG_DISABLED : SG_WAIT_ON;
      SG_WAIT_ON:   if (shdn_s) state_d = SG_DISABLED;
                    else if (on_expired) state_d = SG_WAIT_FLAG;
      SG_WAIT_FLAG: if (shdn_s) state_d = SG_DISABLED;
                    else if (flag_expired) state_d = SG_ON;
      SG_ON:        if (shdn_s) state_d = SG_DISABLED;
      SG_DISABLED:  if (!shdn_s) state_d = SG_WAIT_ON;
      default:      state_d = SG_FAULT;
    endcase
    if (fault_s) state_d = SG_FAULT;
  end

  // Registered outputs, decoded from the next state.
  logic gate_d, flag_low_d, gate_q, flag_low_q;

  always_comb begin
    gate_d     = (state_d == SG_WAIT_FLAG) || (state_d == SG_ON);
    flag_low_d = flag_low_q;
    if (state_d == SG_FAULT)                                flag_low_d = 1'b1;
    else if ((state_d == SG_ON) || (state_d == SG_DISABLED)) flag_low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= SG_FAULT;
      gate_q     <= 1'b0;
      flag_low_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      gate_q     <= gate_d;
      flag_low_q <= flag_low_d;
    end
  end

  assign gate_en_o       = gate_q;
  assign flag_pull_low_o = flag_low_q;

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic fault_s,
  input logic shdn_s,
  input logic on_expired,
  input logic flag_expired,
  input logic gate_en_o,
  input logic flag_pull_low_o
);

  // R2
  fault_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> (!gate_en_o && flag_pull_low_o));

  // R5
  shdn_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_s |=> !gate_en_o);

  // R5
  shdn_releases_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_s && !fault_s) |=> !flag_pull_low_o);

  // R3
  gate_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(on_expired));

  // R4
  flag_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_pull_low_o) |-> ($past(flag_expired) || $past(shdn_s)));

  // R7
  no_close_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> !$past(fault_s));

endmodule

bind supply_guard_ctrl supply_guard_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .fault_s        (fault_s),
  .shdn_s         (shdn_s),
  .on_expired     (on_expired),
  .flag_expired   (flag_expired),
  .gate_en_o      (gate_en_o),
  .flag_pull_low_o(flag_pull_low_o)
);

// File: tb/supply_guard_ctrl_test.sv
`timescale 1ns/1ps
module supply_guard_ctrl_test;

  localparam int D   = 4;
  localparam int TON = 5;
  localparam int TFL = 3;
  localparam int NON = TON * D;
  localparam int NFL = TFL * D;

  localparam int M_F = 0, M_WON = 1, M_WFL = 2, M_ON = 3, M_DIS = 4;

  logic clk = 1'b0;
  logic rst_n, uv, ov, ot, shdn;
  logic gate, flag_low;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   sb_en = 0;

  always #2.5 clk = ~clk;

  supply_guard_ctrl #(
    .TICK_DIV(D), .ON_DELAY_MS(TON), .FLAG_DELAY_MS(TFL), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .uv_low_i(uv), .ov_high_i(ov), .ot_hot_i(ot),
    .shdn_i(shdn), .gate_en_o(gate), .flag_pull_low_o(flag_low)
  );

  // Cycle-level expectation built from the requirements.
  logic p1f, p2f, p1s, p2s, mgate, mflag;
  int   ms, mc, nx, nc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1f <= 1'b1; p2f <= 1'b1; p1s <= 1'b0; p2s <= 1'b0;
      ms <= M_F; mc <= 0; mgate <= 1'b0; mflag <= 1'b1;
    end else begin
      nx = ms; nc = mc;
      case (ms)
        M_F:   if (!p2f) nx = p2s ? M_DIS : M_WON;
        M_WON: if (p2s) nx = M_DIS; else if (mc == NON) nx = M_WFL; else nc = mc + 1;
        M_WFL: if (p2s) nx = M_DIS; else if (mc == NFL) nx = M_ON; else nc = mc + 1;
        M_ON:  if (p2s) nx = M_DIS;
        M_DIS: if (!p2s) nx = M_WON;
        default: nx = M_F;
      endcase
      if (p2f) nx = M_F;
      if (nx != ms) nc = 0;
      p1f <= uv | ov | ot; p2f <= p1f; p1s <= shdn; p2s <= p1s;
      ms <= nx; mc <= nc;
      mgate <= (nx == M_WFL) || (nx == M_ON);
      if (nx == M_F) mflag <= 1'b1;
      else if (nx == M_ON || nx == M_DIS) mflag <= 1'b0;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      M_F:     return "R2";
      M_WON:   return "R3";
      M_WFL:   return "R4";
      M_ON:    return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic expect_out(input string tag, input logic g, input logic f);
    check(tag, "gate_en_o", gate, g);
    check(tag, "flag_pull_low_o", flag_low, f);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_en) begin
      check(tag_of(ms), "gate_en_o vs model", gate, mgate);
      check(tag_of(ms), "flag_pull_low_o vs model", flag_low, mflag);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; uv = 1'b1; ov = 1'b0; ot = 1'b0; shdn = 1'b0;
    step(5);
    expect_out("R1", 1'b0, 1'b1);
    rst_n = 1'b1;
    step(10);
    expect_out("R1", 1'b0, 1'b1);
    sb_en = 1;

    // Power-up sequence.
    uv = 1'b0;
    step(3 + NON); expect_out("R3", 1'b0, 1'b1);
    step(1);       expect_out("R3", 1'b1, 1'b1);
    step(NFL);     expect_out("R4", 1'b1, 1'b1);
    step(1);       expect_out("R4", 1'b1, 1'b0);

    // Overvoltage: exact latency.
    ov = 1'b1;
    step(2); expect_out("R2", 1'b1, 1'b0);
    step(1); expect_out("R2", 1'b0, 1'b1);

    // Shutdown toggling during a fault cannot close the switch.
    shdn = 1'b1; step(5);  expect_out("R7", 1'b0, 1'b1);
    shdn = 1'b0; step(10); expect_out("R7", 1'b0, 1'b1);
    ov = 1'b0;   step(3);  expect_out("R3", 1'b0, 1'b1);

    // Shutdown in mid start-up wait, then release.
    step(5);
    shdn = 1'b1; step(3);  expect_out("R5", 1'b0, 1'b0);
    step(10);              expect_out("R5", 1'b0, 1'b0);
    shdn = 1'b0;
    step(3 + NON); expect_out("R9", 1'b0, 1'b0);
    step(1);       expect_out("R6", 1'b1, 1'b0);
    step(NFL + 2); expect_out("R6", 1'b1, 1'b0);

    // Shutdown from ON leaves the flag released.
    shdn = 1'b1; step(3); expect_out("R5", 1'b0, 1'b0);
    shdn = 1'b0;
    step(3 + NON + 1);    expect_out("R6", 1'b1, 1'b0);

    // Overtemperature pulse in the flag wait restarts everything.
    ot = 1'b1; step(3); expect_out("R8", 1'b0, 1'b1);
    ot = 1'b0;
    step(3 + NON); expect_out("R8", 1'b0, 1'b1);
    step(1);       expect_out("R8", 1'b1, 1'b1);
    step(NFL);     expect_out("R8", 1'b1, 1'b1);
    step(1);       expect_out("R8", 1'b1, 1'b0);

    // Random stretches of faults and shutdowns.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      uv   = (r == 0);
      ov   = (r == 1);
      ot   = (r == 2) || (r == 3 && ($urandom % 2 == 0));
      shdn = ($urandom % 4 == 0);
      step(1 + $urandom % (NON + NFL + 12));
    end

    uv = 1'b0; ov = 1'b0; ot = 1'b0; shdn = 1'b0;
    step(NON + NFL + 10);
    expect_out("R4", 1'b1, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule